// File: doc/BRIEF.md
# Watchdog Timer with Startup Window

This block supervises software liveness through a single kick input. Each time the kick level changes, rising or falling, the timer restarts. If the level stays put for longer than the allowed window, the block raises a one-clock expiry pulse. A reset controller uses that pulse to assert the system reset.

Two windows are used. Each time the system reset releases, a long startup window applies. This gives boot code time to produce its first transition. After that first transition, every later interval is held to the short normal window.

Time is counted in ticks from a free-running prescaler, and both windows are parameters expressed in ticks. A disable input turns off expiry when the kick line is known to be unconnected. The kick input is brought into the clock domain by a synchronizer and then edge-detected.

Top module: `wdg_supervisor`

## Requirements
- R1: While `arst_n` is low, `wd_expire` is 0. After `arst_n` rises with `sys_rst` still high, `wd_expire` stays 0.
- R2: When `sys_rst` falls and no kick transition follows, `wd_expire` pulses once. The pulse comes after `START_TICKS` prescaler ticks, counted from the first clock edge after the release.
- R3: After the first kick transition, the timer uses the normal window. With no further transition, `wd_expire` pulses after `NORM_TICKS` ticks, counted from the cycle in which the synchronized edge is seen.
- R4: A rising edge and a falling edge on `kick_in` each restart the normal window, so steady toggling never causes expiry.
- R5: `wd_expire` is high for exactly one clock. After it, no further pulse comes until `sys_rst` has been asserted and then released again.
- R6: While `sys_rst` is high, the timer is held cleared: kick edges are ignored and no expiry occurs. On release, the startup window applies again, even if the timer was in the normal window before.
- R7: While `wd_off` is high, `wd_expire` never pulses and the count is held at zero. Kick edges still end the startup window. When `wd_off` falls, a full window is timed, starting from the first clock edge at which it is seen low.
- R8: A kick pulse that lasts one full clock period is recognized as two transitions.
- R9: A kick transition reaches the timer `SYNC_STAGES`+1 clock edges after it is applied. `wd_expire` is registered and matches the cycle-exact window behaviour on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | System reset from the reset controller, active high; clears the timer |
| kick_in | input | 1 | Asynchronous kick line; either edge restarts the window |
| wd_off | input | 1 | High when the kick line is unconnected; suppresses expiry |
| wd_expire | output | 1 | One-clock expiry pulse to the reset controller |

## Verification
The bound checker watches the following on every cycle:
- the expiry pulse is a single cycle and is followed by the waiting state;
- neither `sys_rst` nor `wd_off` is ever followed by a pulse;
- an accepted kick edge always zeroes the count and selects the normal window;
- the count stays inside the window that is currently active.

The scenarios in the bench are needed for the rest:
- the exact length of each window in cycles;
- the return to the startup window after a reset taken mid-run;
- recognition of one-cycle kick pulses and of a lone falling edge;
- the window timed afresh after `wd_off` is released.

A behavioural model compared on every clock checks the full timing.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
   typedef enum logic [1:0] {
      WD_IDLE  = 2'd0,   // system reset held, timer cleared
      WD_WAIT  = 2'd1,   // expired, waiting for the reset controller
      WD_START = 2'd2,   // long first window
      WD_RUN   = 2'd3    // normal window
   } wd_state_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/wdg_kick_sync.sv
`timescale 1ns/1ps
module wdg_kick_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic kick_i,
   output logic edge_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) sync_q[0] <= 1'b0;
               else         sync_q[0] <= kick_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) sync_q[gi] <= 1'b0;
               else         sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) prev_q <= 1'b0;
      else         prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign edge_o = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdg_tick_gen.sv
`timescale 1ns/1ps
module wdg_tick_gen #(
   parameter int unsigned TICK_DIV = 4
) (
   input  logic clk,
   input  logic arst_n,
   output logic tick_o
);
   generate
      if (TICK_DIV == 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int unsigned PW = $clog2(TICK_DIV);
         localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)            pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else                    pre_q <= pre_q + 1'b1;
         end
         assign tick_o = (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdg_window_timer.sv
`timescale 1ns/1ps
module wdg_window_timer
   import wdg_pkg::*;
#(
   parameter int unsigned NORM_TICKS  = 5,
   parameter int unsigned START_TICKS = 20,
   parameter int unsigned CNT_W       = 5
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             sys_rst_i,
   input  logic             off_i,
   input  logic             edge_i,
   input  logic             tick_i,
   output logic             expire_o,
   output wd_state_t        state_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_TICKS - 1);
   localparam logic [CNT_W-1:0] NORM_LAST  = CNT_W'(NORM_TICKS - 1);

   wd_state_t        st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, lim;
   logic             fire, exp_q;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      fire  = 1'b0;
      lim   = (st_q == WD_START) ? START_LAST : NORM_LAST;
      if (sys_rst_i) begin
         st_d  = WD_IDLE;
         cnt_d = '0;
      end else begin
         unique case (st_q)
            WD_IDLE: begin
               st_d  = WD_START;
               cnt_d = '0;
            end
            WD_WAIT: cnt_d = '0;
            WD_START, WD_RUN: begin
               if (edge_i) begin
                  st_d  = WD_RUN;
                  cnt_d = '0;
               end else if (off_i) begin
                  cnt_d = '0;
               end else if (tick_i) begin
                  if (cnt_q == lim) begin
                     fire  = 1'b1;
                     st_d  = WD_WAIT;
                     cnt_d = '0;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end
            end
            default: st_d = WD_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st_q  <= WD_IDLE;
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         exp_q <= fire;
      end
   end

   assign expire_o = exp_q;
   assign state_o  = st_q;
   assign cnt_o    = cnt_q;
endmodule

// File: rtl/wdg_supervisor.sv
`timescale 1ns/1ps
module wdg_supervisor
   import wdg_pkg::*;
#(
   parameter int unsigned TICK_DIV    = 1000,
   parameter int unsigned NORM_TICKS  = 1600,
   parameter int unsigned START_TICKS = 54000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic sys_rst,
   input  logic kick_in,
   input  logic wd_off,
   output logic wd_expire
);
   localparam int unsigned CNT_W = cnt_width(START_TICKS);

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (NORM_TICKS < 2) begin : g_bad_norm
         $error("NORM_TICKS must be at least 2");
      end
      if (START_TICKS <= NORM_TICKS) begin : g_bad_start
         $error("START_TICKS must exceed NORM_TICKS");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             kick_edge;
   logic             tick;
   wd_state_t        tmr_state;
   logic [CNT_W-1:0] tmr_cnt;

   wdg_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .arst_n(arst_n), .kick_i(kick_in), .edge_o(kick_edge)
   );

   wdg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .arst_n(arst_n), .tick_o(tick)
   );

   wdg_window_timer #(
      .NORM_TICKS(NORM_TICKS), .START_TICKS(START_TICKS), .CNT_W(CNT_W)
   ) u_tmr (
      .clk(clk), .arst_n(arst_n), .sys_rst_i(sys_rst), .off_i(wd_off),
      .edge_i(kick_edge), .tick_i(tick), .expire_o(wd_expire),
      .state_o(tmr_state), .cnt_o(tmr_cnt)
   );
endmodule

// File: rtl/wdg_supervisor_chk.sv
`timescale 1ns/1ps
module wdg_supervisor_chk
   import wdg_pkg::*;
#(
   parameter int unsigned NORM_TICKS  = 5,
   parameter int unsigned START_TICKS = 20,
   parameter int unsigned CNT_W       = 5
) (
   input logic             clk,
   input logic             arst_n,
   input logic             sys_rst,
   input logic             wd_off,
   input logic             wd_expire,
   input logic             kick_edge,
   input wd_state_t        tmr_state,
   input logic [CNT_W-1:0] tmr_cnt
);
   // R5
   pulse_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
      wd_expire |=> !wd_expire);
   // R5
   hold_after_expire_chk: assert property (@(posedge clk) disable iff (!arst_n)
      wd_expire |-> (tmr_state == WD_WAIT));
   // R6
   rst_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
      sys_rst |=> (!wd_expire && tmr_cnt == '0 && tmr_state == WD_IDLE));
   // R7
   off_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
      wd_off |=> !wd_expire);
   // R4
   edge_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (kick_edge && !sys_rst && (tmr_state == WD_START || tmr_state == WD_RUN))
      |=> (tmr_cnt == '0 && tmr_state == WD_RUN && !wd_expire));
   // R2
   start_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
      tmr_cnt < CNT_W'(START_TICKS));
   // R3
   run_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (tmr_state == WD_RUN) |-> (tmr_cnt < CNT_W'(NORM_TICKS)));
endmodule

bind wdg_supervisor wdg_supervisor_chk #(
   .NORM_TICKS(NORM_TICKS), .START_TICKS(START_TICKS), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .arst_n(arst_n), .sys_rst(sys_rst), .wd_off(wd_off),
   .wd_expire(wd_expire), .kick_edge(kick_edge), .tmr_state(tmr_state),
   .tmr_cnt(tmr_cnt)
);

// File: tb/sim_wdg_supervisor.sv
`timescale 1ns/1ps
module sim_wdg_supervisor;
   localparam int DIV = 4;
   localparam int NT  = 5;
   localparam int ST  = 20;
   localparam int NS  = 2;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic sys_rst = 1'b1;
   logic kick_in = 1'b0;
   logic wd_off = 1'b0;
   logic wd_expire;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int n_exp = 0;
   int last_exp = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   wdg_supervisor #(.TICK_DIV(DIV), .NORM_TICKS(NT), .START_TICKS(ST),
                    .SYNC_STAGES(NS)) u0 (
      .clk(clk), .arst_n(arst_n), .sys_rst(sys_rst), .kick_in(kick_in),
      .wd_off(wd_off), .wd_expire(wd_expire));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference: phase 0 held, 1 waiting, 2 first window, 3 normal
   int m_ph = 0, m_cnt = 0, m_pre = 0, m_exp = 0;
   bit m_hist[$];

   always @(posedge clk) begin
      cyc++;
      if (!arst_n) begin
         m_ph = 0; m_cnt = 0; m_pre = 0; m_exp = 0;
         m_hist = {};
         for (int i = 0; i <= NS; i++) m_hist.push_back(1'b0);
      end else begin
         bit seen, tk;
         int lim;
         seen = m_hist[NS-1] ^ m_hist[NS];
         tk = (m_pre == DIV - 1);
         lim = (m_ph == 2) ? ST : NT;
         m_exp = 0;
         if (sys_rst) begin
            m_ph = 0; m_cnt = 0;
         end else if (m_ph == 0) begin
            m_ph = 2; m_cnt = 0;
         end else if (m_ph >= 2) begin
            if (seen) begin m_ph = 3; m_cnt = 0; end
            else if (wd_off) m_cnt = 0;
            else if (tk) begin
               m_cnt++;
               if (m_cnt == lim) begin m_exp = 1; m_ph = 1; m_cnt = 0; end
            end
         end
         m_pre = tk ? 0 : m_pre + 1;
         void'(m_hist.pop_back());
         m_hist.push_front(kick_in);
      end
   end

   always @(negedge clk) begin
      if (wd_expire) begin n_exp++; last_exp = cyc; end
      if (arst_n) chk(wd_expire === m_exp[0], "R9 cycle-model", int'(wd_expire), m_exp);
   end

   always @(negedge clk) begin
      if (!done && cyc > 20000) begin
         done = 1;
         chk(1'b0, "watchdog timeout", cyc, 20000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reset_cycle(input bit kv);
      sys_rst = 1'b1; kick_in = kv; w(8); sys_rst = 1'b0;
   endtask

   initial begin
      int e, c;
      // R1 reset state
      w(3);
      chk(wd_expire == 1'b0, "R1 expire during arst", int'(wd_expire), 0);
      arst_n = 1'b1;
      w(4);
      // R6 edges ignored while system reset held
      repeat (3) begin kick_in = ~kick_in; w(2); end
      w(60);
      chk(n_exp == 0, "R1 no expiry before release", n_exp, 0);
      chk(n_exp == 0, "R6 kicks ignored in reset", n_exp, 0);

      // R2 startup window
      e = n_exp; sys_rst = 1'b0; c = cyc;
      w(100);
      chk(n_exp - e == 1, "R2 one startup expiry", n_exp - e, 1);
      chk(last_exp - c >= ST*DIV - 2 && last_exp - c <= ST*DIV + 1,
          "R2 startup delay", last_exp - c, ST*DIV);
      // R5 no re-fire without reset
      e = n_exp; w(150);
      chk(n_exp - e == 0, "R5 silent after expiry", n_exp - e, 0);

      // R3 normal window after first kick
      reset_cycle(1'b0); w(8);
      e = n_exp; kick_in = 1'b1; c = cyc;
      w(40);
      chk(n_exp - e == 1, "R3 one normal expiry", n_exp - e, 1);
      chk(last_exp - c >= NT*DIV && last_exp - c <= NT*DIV + 3,
          "R3 normal delay", last_exp - c, NT*DIV + 3);

      // R4 toggling keeps it alive; lone falling edge restarts window
      reset_cycle(1'b0); w(5);
      e = n_exp;
      repeat (20) begin w(12); kick_in = ~kick_in; end
      w(12); kick_in = 1'b1; w(12);
      chk(n_exp - e == 0, "R4 toggling prevents expiry", n_exp - e, 0);
      kick_in = 1'b0; c = cyc;
      w(40);
      chk(n_exp - e == 1, "R4 expiry after last falling edge", n_exp - e, 1);
      chk(last_exp - c >= NT*DIV && last_exp - c <= NT*DIV + 3,
          "R4 falling edge restarts window", last_exp - c, NT*DIV + 3);

      // R8 one-cycle pulses
      reset_cycle(1'b0); w(5);
      e = n_exp;
      repeat (15) begin w(9); kick_in = 1'b1; w(1); kick_in = 1'b0; end
      c = cyc;
      chk(n_exp - e == 0, "R8 short pulses keep alive", n_exp - e, 0);
      w(40);
      chk(last_exp - c >= NT*DIV && last_exp - c <= NT*DIV + 3,
          "R8 pulse trailing edge seen", last_exp - c, NT*DIV + 3);

      // R7 disable
      wd_off = 1'b1; reset_cycle(1'b0);
      e = n_exp; w(200);
      chk(n_exp - e == 0, "R7 no expiry while disabled", n_exp - e, 0);
      kick_in = 1'b1; w(10);
      wd_off = 1'b0; c = cyc;
      w(40);
      chk(n_exp - e == 1, "R7 expiry after enable", n_exp - e, 1);
      chk(last_exp - c >= NT*DIV - 3 && last_exp - c <= NT*DIV,
          "R7 full window after enable", last_exp - c, NT*DIV);

      // R6 reset mid-run restores startup window
      reset_cycle(1'b0); w(5);
      kick_in = 1'b1; w(10);
      sys_rst = 1'b1; w(10);
      e = n_exp; sys_rst = 1'b0; c = cyc;
      w(100);
      chk(n_exp - e == 1, "R6 one expiry after re-release", n_exp - e, 1);
      chk(last_exp - c >= ST*DIV - 2 && last_exp - c <= ST*DIV + 1,
          "R6 startup window re-entered", last_exp - c, ST*DIV);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule